// File: doc/BRIEF.md
# BCD calendar clock register file

This block keeps a real-time calendar (seconds, minutes, hours, day of week, date, month and year) in packed BCD, 24-hour form, and shows it to software as eight bytes at the top of an 8K-byte address space. An external prescaler supplies a one-cycle pulse once per second. On each pulse the internal counters advance and, unless a halt bit is set, the visible bytes are refreshed from them in the same cycle.

The visible bytes are a shadow of the counters, not the counters themselves. Software sets the read-halt bit to take a coherent snapshot while time keeps running. To set the clock, it sets the write-halt bit, writes the new values into the shadow and then clears the bit, which copies the shadow into the counters. A stop bit in the seconds byte freezes the counters themselves. It comes out of reset set.

The bus is a plain synchronous byte port: address, write data and a write strobe, with the read data a combinational function of the address.

Top module: `rtc_shadow_regs`

## Requirements
- R1: The address offsets in the top eight locations read as: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Any address outside the top eight reads 8'h00.
- R2: After reset the eight bytes read 00, 80, 00, 00, 01, 01, 01, 00 (offsets 0 to 7). Seconds bit 7, the stop bit, is therefore 1, and the counters do not move.
- R3: With stop clear, a tick advances seconds in BCD. Carries ripple at seconds 59, minutes 59 and hours 23, and each hour carry also advances the day of week from 7 back to 1 and the date. Month 12 wraps to 01 and year 99 wraps to 00. All visible bytes show the new values from the cycle after the tick edge.
- R4: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. February ends at 29 when the year is divisible by 4 (00 included) and at 28 otherwise.
- R5: While the stop bit held in the counters is 1, ticks leave every counter unchanged.
- R6: While control bit 6 is 1, the visible time bytes keep their values and the counters keep running. After the bit is cleared, the next tick shows the running count.
- R7: While control bit 7 is 1, ticks do not refresh the visible bytes and bus writes land in them. A control write that clears bit 7 while it is 1 loads the counters from the shadow: seconds bits 6:0, stop from seconds bit 7, minutes bits 6:0, hours bits 5:0, day bits 2:0, frequency-test from day bit 6, date bits 5:0, month bits 4:0, and year.
- R8: A control write that sets a halt bit in the same cycle as a tick does not block that tick: the whole update lands.
- R9: A write to a time byte while neither halt bit is set changes only the shadow. The next tick overwrites it with the count, and if the write and the tick fall in the same cycle the tick value wins.
- R10: A refresh shows the bits defined as zero as 0. Bit 6 of the day byte shows the frequency-test enable loaded through R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 8 | Read data for addr |

## Verification
The calendar is tried with times loaded just before the year boundary, before the end of February in years 23, 24 and 00, and before the end of a 30-day month. These separate a correct month-length and leap decision from an off-by-one or a missed carry. Interleaved halt-bit sequences tell apart a shadow that truly freezes from one that drifts, and show whether a release reloads the counters or not. Same-cycle collisions of a tick with control or time writes expose the priority between refresh and bus writes. A reference model checks the read port on every cycle through a long free run with rotating addresses.

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  output logic [7:0]        rdata
);
  localparam int TOP_W = ADDR_W - 3;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic       stop_q, ft_q;
  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q, date_q;
  logic [2:0] day_q;
  logic [4:0] mon_q;
  logic [7:0] yr_q;
  logic [7:0] sh [8];

  logic hit, load, halt, upd;
  logic [2:0] sel;
  assign hit  = addr[ADDR_W-1:3] == {TOP_W{1'b1}};
  assign sel  = addr[2:0];
  assign halt = sh[0][7] | sh[0][6];
  assign load = we && hit && sel == 3'd0 && sh[0][7] && !wdata[7];
  assign upd  = tick && !halt;
  assign rdata = hit ? sh[sel] : 8'h00;

  logic leap;
  logic [5:0] last;
  assign leap = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                        : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);
  always_comb
    case (mon_q)
      5'h02:                      last = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last = 6'h30;
      default:                    last = 6'h31;
    endcase

  logic [7:0] i_sec, i_min, i_hr, i_date, i_mon, i_yr;
  assign i_sec  = bcd_inc({1'b0, sec_q});
  assign i_min  = bcd_inc({1'b0, min_q});
  assign i_hr   = bcd_inc({2'b0, hr_q});
  assign i_date = bcd_inc({2'b0, date_q});
  assign i_mon  = bcd_inc({3'b0, mon_q});
  assign i_yr   = bcd_inc(yr_q);

  logic c_s, c_m, c_h, c_d, c_mo;
  assign c_s  = tick && !stop_q;
  assign c_m  = c_s  && sec_q  == 7'h59;
  assign c_h  = c_m  && min_q  == 7'h59;
  assign c_d  = c_h  && hr_q   == 6'h23;
  assign c_mo = c_d  && date_q == last;

  logic [6:0] n_sec, n_min;
  logic [5:0] n_hr, n_date;
  logic [2:0] n_day;
  logic [4:0] n_mon;
  logic [7:0] n_yr;
  assign n_sec  = !c_s ? sec_q  : (c_m ? 7'h00 : i_sec[6:0]);
  assign n_min  = !c_m ? min_q  : (c_h ? 7'h00 : i_min[6:0]);
  assign n_hr   = !c_h ? hr_q   : (c_d ? 6'h00 : i_hr[5:0]);
  assign n_day  = !c_d ? day_q  : (day_q == 3'd7 ? 3'd1 : day_q + 3'd1);
  assign n_date = !c_d ? date_q : (c_mo ? 6'h01 : i_date[5:0]);
  assign n_mon  = !c_mo ? mon_q : (mon_q == 5'h12 ? 5'h01 : i_mon[4:0]);
  assign n_yr   = !(c_mo && mon_q == 5'h12) ? yr_q : (yr_q == 8'h99 ? 8'h00 : i_yr);

  logic [7:0] cp [8];
  always_comb begin
    cp[0] = sh[0];
    cp[1] = {stop_q, n_sec};
    cp[2] = {1'b0, n_min};
    cp[3] = {2'b0, n_hr};
    cp[4] = {1'b0, ft_q, 3'b0, n_day};
    cp[5] = {2'b0, n_date};
    cp[6] = {3'b0, n_mon};
    cp[7] = n_yr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b1; ft_q <= 1'b0;
      sec_q <= '0; min_q <= '0; hr_q <= '0;
      day_q <= 3'd1; date_q <= 6'h01; mon_q <= 5'h01; yr_q <= '0;
      for (int i = 0; i < 8; i++) sh[i] <= 8'h00;
      sh[1] <= 8'h80; sh[4] <= 8'h01; sh[5] <= 8'h01; sh[6] <= 8'h01;
    end else begin
      if (load) begin
        stop_q <= sh[1][7]; sec_q <= sh[1][6:0];
        min_q  <= sh[2][6:0]; hr_q <= sh[3][5:0];
        ft_q   <= sh[4][6]; day_q <= sh[4][2:0];
        date_q <= sh[5][5:0]; mon_q <= sh[6][4:0]; yr_q <= sh[7];
      end else begin
        sec_q <= n_sec; min_q <= n_min; hr_q <= n_hr; day_q <= n_day;
        date_q <= n_date; mon_q <= n_mon; yr_q <= n_yr;
      end
      for (int i = 0; i < 8; i++)
        if (upd && i != 0) sh[i] <= cp[i];
        else if (we && hit && sel == 3'(i)) sh[i] <= wdata;
    end
  end

  logic [43:0] cnt_vec;
  logic [55:0] shd_vec;
  assign cnt_vec = {stop_q, ft_q, sec_q, min_q, hr_q, day_q, date_q, mon_q, yr_q};
  assign shd_vec = {sh[1], sh[2], sh[3], sh[4], sh[5], sh[6], sh[7]};

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_q) && !$past(load)) |-> $stable(cnt_vec));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(load)) |-> $stable(cnt_vec));
  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halt) && !$past(we)) |-> $stable(shd_vec));
  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (sec_q == $past(sh[1][6:0]) && stop_q == $past(sh[1][7]) && yr_q == $past(sh[7])));
  // R9
  refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd) |-> (sh[1] == {stop_q, sec_q} && sh[7] == yr_q && sh[2] == {1'b0, min_q}));
endmodule

// File: tb/test_rtc_shadow_regs.sv
module test_rtc_shadow_regs;
  localparam int PER = 10;
  localparam logic [12:0] C = 13'h1FF8;

  logic clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [12:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  rtc_shadow_regs i_rtc_shadow_regs (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
                                     .wdata(wdata), .we(we), .rdata(rdata));
  always #(PER/2) clk = ~clk;

  int total = 0, failed = 0;
  string cur_req = "R2";
  int msec, mmin, mhr, mday, mdate, mmon, myr, mstop, mft;
  int msh [8];

  function automatic int bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int dec(int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      msec = 0; mmin = 0; mhr = 0; mday = 1; mdate = 1; mmon = 1; myr = 0; mstop = 1; mft = 0;
      msh = '{0, 8'h80, 0, 0, 1, 1, 1, 0};
    end else begin
      automatic int ctl = msh[0];
      automatic bit hit = addr[12:3] == 10'h3FF;
      automatic int sel = int'(addr[2:0]);
      automatic bit ld = we && hit && sel == 0 && ctl[7] && !wdata[7];
      automatic bit up = tick && !(ctl[7] || ctl[6]);
      if (ld) begin
        mstop = msh[1] >> 7; msec = dec(msh[1] & 8'h7F); mmin = dec(msh[2] & 8'h7F);
        mhr = dec(msh[3] & 8'h3F); mft = (msh[4] >> 6) & 1; mday = msh[4] & 7;
        mdate = dec(msh[5] & 8'h3F); mmon = dec(msh[6] & 8'h1F); myr = dec(msh[7]);
      end else if (tick && !mstop) begin
        msec++;
        if (msec == 60) begin msec = 0; mmin++; end
        if (mmin == 60) begin mmin = 0; mhr++; end
        if (mhr == 24) begin
          mhr = 0; mday = (mday == 7) ? 1 : mday + 1; mdate++;
          if (mdate > dim(mmon, myr)) begin
            mdate = 1; mmon++;
            if (mmon == 13) begin mmon = 1; myr = (myr + 1) % 100; end
          end
        end
      end
      if (we && hit && (sel == 0 || !up)) msh[sel] = int'(wdata);
      if (up) begin
        msh[1] = (mstop << 7) | bcd(msec); msh[2] = bcd(mmin); msh[3] = bcd(mhr);
        msh[4] = (mft << 6) | mday; msh[5] = bcd(mdate); msh[6] = bcd(mmon); msh[7] = bcd(myr);
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    automatic int exp = (addr[12:3] == 10'h3FF) ? msh[addr[2:0]] : 0;
    check(rdata === 8'(exp), cur_req, int'(rdata), exp);
  end

  task automatic step(logic [12:0] a, logic [7:0] d, bit w, bit t);
    @(posedge clk); #1; addr = a; wdata = d; we = w; tick = t;
  endtask
  task automatic ticks(int n);
    repeat (n) step(13'h0, 8'h0, 0, 1);
    step(13'h0, 8'h0, 0, 0);
  endtask
  task automatic expect_reg(logic [12:0] a, logic [7:0] e, string req);
    step(a, 8'h0, 0, 0);
    @(negedge clk);
    check(rdata === e, req, int'(rdata), int'(e));
  endtask
  task automatic set_time(logic [7:0] s, mi, h, dw, dt, mo, y);
    step(C, 8'h80, 1, 0);
    step(C + 1, s, 1, 0); step(C + 2, mi, 1, 0); step(C + 3, h, 1, 0);
    step(C + 4, dw, 1, 0); step(C + 5, dt, 1, 0); step(C + 6, mo, 1, 0); step(C + 7, y, 1, 0);
    step(C, 8'h00, 1, 0);
    step(13'h0, 8'h0, 0, 0);
  endtask

  bit done = 0;
  initial begin
    #(PER * 100000);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expect_reg(C, 8'h00, "R2"); expect_reg(C + 1, 8'h80, "R2"); expect_reg(C + 2, 8'h00, "R2");
    expect_reg(C + 3, 8'h00, "R2"); expect_reg(C + 4, 8'h01, "R2"); expect_reg(C + 5, 8'h01, "R2");
    expect_reg(C + 6, 8'h01, "R2"); expect_reg(C + 7, 8'h00, "R2");
    cur_req = "R1"; expect_reg(13'h0100, 8'h00, "R1"); expect_reg(13'h1FF0, 8'h00, "R1");
    cur_req = "R5"; ticks(3); expect_reg(C + 1, 8'h80, "R5");

    cur_req = "R3";
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99); ticks(1);
    expect_reg(C + 1, 8'h00, "R3"); expect_reg(C + 2, 8'h00, "R3"); expect_reg(C + 3, 8'h00, "R3");
    expect_reg(C + 4, 8'h01, "R3"); expect_reg(C + 5, 8'h01, "R3"); expect_reg(C + 6, 8'h01, "R3");
    expect_reg(C + 7, 8'h00, "R3");

    cur_req = "R4";
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23); ticks(1);
    expect_reg(C + 5, 8'h01, "R4"); expect_reg(C + 6, 8'h03, "R4");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24); ticks(1);
    expect_reg(C + 5, 8'h29, "R4"); expect_reg(C + 6, 8'h02, "R4");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00); ticks(1);
    expect_reg(C + 5, 8'h29, "R4");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24); ticks(1);
    expect_reg(C + 5, 8'h01, "R4"); expect_reg(C + 6, 8'h05, "R4");

    cur_req = "R5";
    set_time(8'h85, 8'h10, 8'h10, 8'h03, 8'h10, 8'h10, 8'h10); ticks(4);
    expect_reg(C + 1, 8'h85, "R5");

    cur_req = "R6";
    set_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h24); ticks(3);
    step(C, 8'h40, 1, 0); ticks(5);
    expect_reg(C + 1, 8'h03, "R6");
    step(C, 8'h00, 1, 0); expect_reg(C + 1, 8'h03, "R6");
    ticks(1); expect_reg(C + 1, 8'h09, "R6");

    cur_req = "R7";
    step(C, 8'h80, 1, 0); step(C + 1, 8'h30, 1, 0); expect_reg(C + 1, 8'h30, "R7");
    ticks(2); expect_reg(C + 1, 8'h30, "R7");
    step(C, 8'h00, 1, 0); ticks(1); expect_reg(C + 1, 8'h31, "R7");

    cur_req = "R8";
    step(C, 8'h40, 1, 1); expect_reg(C + 1, 8'h32, "R8");
    ticks(1); expect_reg(C + 1, 8'h32, "R8");
    step(C, 8'h00, 1, 0); ticks(1); expect_reg(C + 1, 8'h34, "R8");

    cur_req = "R9";
    step(C + 2, 8'h45, 1, 0); expect_reg(C + 2, 8'h45, "R9");
    ticks(1); expect_reg(C + 2, 8'h00, "R9"); expect_reg(C + 1, 8'h35, "R9");
    step(C + 1, 8'h77, 1, 1); expect_reg(C + 1, 8'h36, "R9");

    cur_req = "R10";
    set_time(8'h00, 8'h00, 8'hC5, 8'h45, 8'h01, 8'h01, 8'h24); ticks(1);
    expect_reg(C + 3, 8'h05, "R10"); expect_reg(C + 4, 8'h45, "R10"); expect_reg(C + 1, 8'h01, "R10");

    cur_req = "R3";
    set_time(8'h50, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h99); ticks(100);
    for (int k = 0; k < 600; k++) step(C + 13'(k % 8), 8'h0, 0, (k % 3) == 0);
    step(13'h0, 8'h0, 0, 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule